// File: doc/BRIEF.md
# DMA Modulo Address Generator

This block produces the running source and destination addresses for one DMA channel. Each side is loaded with a start address, a signed 16-bit step that is applied after every completed access, a transfer-size code, a circular-window code and a signed end-of-loop adjustment. A minor-loop offset is shared by both sides, and each side has its own enable bit for it. After the load, strobes from the transfer engine move the addresses along. An access-done strobe (read-done for the source, write-done for the destination) adds the step. Minor-loop completion adds the minor-loop offset where it is enabled. Major-loop completion adds the adjustment.

The window code confines each step to a power-of-two region, so the address walks a circular buffer. Misaligned configurations are caught at load time and freeze the side until the next load. The two sides are identical, independent instances of the same logic. They share only the load strobe, the minor-loop offset value and the loop-completion strobes.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset both addresses are zero and all error flags are clear. A load strobe places each side's start address on its address output in the next cycle, and the side's error flags are recomputed from the new configuration.
- R2: The 3-bit size codes 0, 1, 2, 4 and 5 mean access widths of 1, 2, 4, 16 and 32 bytes. Codes 3, 6 and 7 set the side's size-error flag at load and raise neither of the other two flags.
- R3: An access-done strobe adds the sign-extended 16-bit step to that side's address.
- R4: With window code n from 1 to 31, an access step changes only address bits [n-1:0], and all higher bits keep their earlier value. Code 0, or any n of at least the address width, applies the step without wrapping.
- R5: A minor-done strobe adds the sign-extended minor-loop offset, without wrapping, to each side whose enable was set at load. A side whose enable is clear keeps its address.
- R6: A major-done strobe adds the full-width adjustment to each side's address.
- R7: When several strobes arrive in one cycle, the step (with wrapping) is applied first, then the minor-loop offset, then the major adjustment.
- R8: The address-error flag is set at load when the start address is not a multiple of a valid access width.
- R9: The offset-error flag is set at load when the step is not a multiple of a valid access width.
- R10: Error flags hold until the next load. While any flag of a side is set, that side's address does not change.
- R11: With no strobe, an address holds its value. Source strobes never alter the destination address, and destination strobes never alter the source address.
- R12: A load in the same cycle as other strobes takes priority, and those strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Load configuration on both sides |
| src_start | input | AW | Source start address |
| src_off | input | OW | Source signed step per access |
| src_size | input | 3 | Source size code |
| src_mod | input | 5 | Source window code |
| src_last | input | AW | Source end-of-loop adjustment |
| src_mloff_en | input | 1 | Apply the minor-loop offset to the source |
| dst_start | input | AW | Destination start address |
| dst_off | input | OW | Destination signed step per access |
| dst_size | input | 3 | Destination size code |
| dst_mod | input | 5 | Destination window code |
| dst_last | input | AW | Destination end-of-loop adjustment |
| dst_mloff_en | input | 1 | Apply the minor-loop offset to the destination |
| mloff | input | MW | Signed minor-loop offset, latched at load |
| rd_done | input | 1 | Source access completed |
| wr_done | input | 1 | Destination access completed |
| minor_done | input | 1 | Minor loop completed |
| major_done | input | 1 | Major loop completed |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| src_addr_err | output | 1 | Source start misaligned |
| src_off_err | output | 1 | Source step misaligned |
| src_size_err | output | 1 | Source size code invalid |
| dst_addr_err | output | 1 | Destination start misaligned |
| dst_off_err | output | 1 | Destination step misaligned |
| dst_size_err | output | 1 | Destination size code invalid |

## Verification
The bench steps an address across its window edge in both directions, and does the same at the widest window and with wrapping off. A design that masked the wrong bits would leak a carry into the upper bits or would clear them. One directed case fires all three strobes at once, with values chosen so that applying the minor offset before the wrapped step produces a different address; a design with the order reversed fails it. All eight size codes are loaded against aligned and misaligned starts and steps, which catches a wrong width table or a flag raised for a reserved code. Random stimulus mixes loads, strobes and errored configurations so that errors that fail to stick, updates that leak while frozen, and strobes that cross between the sides all show up.

// File: rtl/dmaag_pkg.sv
package dmaag_pkg;
  localparam int MODW = 5;
  localparam int ALIGNW = 5;

  typedef enum logic [2:0] {
    SZ_B1 = 3'd0, SZ_B2 = 3'd1, SZ_B4 = 3'd2, SZ_RSV3 = 3'd3,
    SZ_B16 = 3'd4, SZ_B32 = 3'd5, SZ_RSV6 = 3'd6, SZ_RSV7 = 3'd7
  } xfer_sz_e;

  typedef struct packed {
    logic addr_err;
    logic off_err;
    logic size_err;
  } err_t;

  function automatic logic size_valid(input logic [2:0] code);
    case (xfer_sz_e'(code))
      SZ_B1, SZ_B2, SZ_B4, SZ_B16, SZ_B32: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // low-bit mask that must be zero for an aligned value
  function automatic logic [ALIGNW-1:0] size_low_mask(input logic [2:0] code);
    case (xfer_sz_e'(code))
      SZ_B2:   return 5'b00001;
      SZ_B4:   return 5'b00011;
      SZ_B16:  return 5'b01111;
      SZ_B32:  return 5'b11111;
      default: return 5'b00000;
    endcase
  endfunction
endpackage

// File: rtl/dmaag_align_chk.sv
module dmaag_align_chk
  import dmaag_pkg::*;
(
  input  logic [ALIGNW-1:0] start_lo,
  input  logic [ALIGNW-1:0] off_lo,
  input  logic [2:0]        size,
  output err_t              chk
);
  logic             valid;
  logic [ALIGNW-1:0] m;

  always_comb begin
    valid        = size_valid(size);
    m            = size_low_mask(size);
    chk.size_err = !valid;
    chk.addr_err = valid && |(start_lo & m);
    chk.off_err  = valid && |(off_lo & m);
  end
endmodule

// File: rtl/dmaag_step.sv
module dmaag_step
  import dmaag_pkg::*;
#(
  parameter int AW = 32,
  parameter int OW = 16,
  parameter int MW = 20
) (
  input  logic [AW-1:0]   cur,
  input  logic            acc,
  input  logic            minor,
  input  logic            major,
  input  logic [OW-1:0]   off,
  input  logic [MODW-1:0] mod,
  input  logic [MW-1:0]   mloff,
  input  logic            mloff_en,
  input  logic [AW-1:0]   last,
  output logic [AW-1:0]   win,
  output logic [AW-1:0]   after_acc,
  output logic [AW-1:0]   after_minor,
  output logic [AW-1:0]   nxt
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  function automatic logic [AW-1:0] win_mask(input logic [MODW-1:0] n);
    if (n == '0 || int'(n) >= AW) return '1;
    return (ONE << n) - ONE;
  endfunction

  function automatic logic [AW-1:0] merge(input logic [AW-1:0] old_a,
                                          input logic [AW-1:0] sum,
                                          input logic [AW-1:0] m);
    return (old_a & ~m) | (sum & m);
  endfunction

  function automatic logic [AW-1:0] sext_off(input logic [OW-1:0] v);
    return {{(AW-OW){v[OW-1]}}, v};
  endfunction

  function automatic logic [AW-1:0] sext_ml(input logic [MW-1:0] v);
    return {{(AW-MW){v[MW-1]}}, v};
  endfunction

  always_comb begin
    win         = win_mask(mod);
    after_acc   = acc ? merge(cur, cur + sext_off(off), win) : cur;
    after_minor = (minor && mloff_en) ? after_acc + sext_ml(mloff) : after_acc;
    nxt         = major ? after_minor + last : after_minor;
  end
endmodule

// File: rtl/dmaag_side.sv
module dmaag_side
  import dmaag_pkg::*;
#(
  parameter int AW = 32,
  parameter int OW = 16,
  parameter int MW = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [AW-1:0]   start,
  input  logic [OW-1:0]   off,
  input  logic [2:0]      size,
  input  logic [MODW-1:0] mod,
  input  logic [AW-1:0]   last,
  input  logic            mloff_en,
  input  logic [MW-1:0]   mloff,
  input  logic            acc,
  input  logic            minor,
  input  logic            major,
  output logic [AW-1:0]   addr,
  output err_t            err
);
  logic [AW-1:0]   addr_q, last_q;
  logic [OW-1:0]   off_q;
  logic [MODW-1:0] mod_q;
  logic [MW-1:0]   ml_q;
  logic            en_q;
  err_t            err_q, chk_err;
  logic            any_err;
  logic            upd_en;
  logic [AW-1:0]   win, after_acc, after_minor, nxt;

  dmaag_align_chk u_chk (
    .start_lo (start[ALIGNW-1:0]),
    .off_lo   (off[ALIGNW-1:0]),
    .size     (size),
    .chk      (chk_err)
  );

  dmaag_step #(.AW(AW), .OW(OW), .MW(MW)) u_step (
    .cur         (addr_q),
    .acc         (acc),
    .minor       (minor),
    .major       (major),
    .off         (off_q),
    .mod         (mod_q),
    .mloff       (ml_q),
    .mloff_en    (en_q),
    .last        (last_q),
    .win         (win),
    .after_acc   (after_acc),
    .after_minor (after_minor),
    .nxt         (nxt)
  );

  assign any_err = |err_q;
  assign upd_en  = !load && !any_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      last_q <= '0;
      off_q  <= '0;
      mod_q  <= '0;
      ml_q   <= '0;
      en_q   <= 1'b0;
      err_q  <= '0;
    end else if (load) begin
      addr_q <= start;
      last_q <= last;
      off_q  <= off;
      mod_q  <= mod;
      ml_q   <= mloff;
      en_q   <= mloff_en;
      err_q  <= chk_err;
    end else if (upd_en) begin
      addr_q <= nxt;
    end
  end

  assign addr = addr_q;
  assign err  = err_q;

  // R1
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr == $past(start)) && (err == $past(chk_err)));

  // R2
  size_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> err.size_err == !size_valid($past(size)));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && any_err) |=> err == $past(err));

  // R10
  frozen_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && any_err) |=> $stable(addr));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !acc && !minor && !major) |=> $stable(addr));

  // R4
  window_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && acc && !minor && !major) |=> ((addr ^ $past(addr)) & ~$past(win)) == '0);
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dmaag_pkg::*;
#(
  parameter int AW = 32,
  parameter int OW = 16,
  parameter int MW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] src_start,
  input  logic [OW-1:0] src_off,
  input  logic [2:0]    src_size,
  input  logic [4:0]    src_mod,
  input  logic [AW-1:0] src_last,
  input  logic          src_mloff_en,
  input  logic [AW-1:0] dst_start,
  input  logic [OW-1:0] dst_off,
  input  logic [2:0]    dst_size,
  input  logic [4:0]    dst_mod,
  input  logic [AW-1:0] dst_last,
  input  logic          dst_mloff_en,
  input  logic [MW-1:0] mloff,
  input  logic          rd_done,
  input  logic          wr_done,
  input  logic          minor_done,
  input  logic          major_done,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          src_addr_err,
  output logic          src_off_err,
  output logic          src_size_err,
  output logic          dst_addr_err,
  output logic          dst_off_err,
  output logic          dst_size_err
);
  localparam int NSIDE = 2;

  logic [NSIDE-1:0][AW-1:0]   start_v, last_v, addr_v;
  logic [NSIDE-1:0][OW-1:0]   off_v;
  logic [NSIDE-1:0][2:0]      size_v;
  logic [NSIDE-1:0][MODW-1:0] mod_v;
  logic [NSIDE-1:0]           en_v, acc_v;
  err_t                       err_v [NSIDE];

  // index 0 is the source side, index 1 the destination side
  assign start_v = {dst_start, src_start};
  assign last_v  = {dst_last, src_last};
  assign off_v   = {dst_off, src_off};
  assign size_v  = {dst_size, src_size};
  assign mod_v   = {dst_mod, src_mod};
  assign en_v    = {dst_mloff_en, src_mloff_en};
  assign acc_v   = {wr_done, rd_done};

  for (genvar gs = 0; gs < NSIDE; gs++) begin : g_side
    dmaag_side #(.AW(AW), .OW(OW), .MW(MW)) u_side (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .start    (start_v[gs]),
      .off      (off_v[gs]),
      .size     (size_v[gs]),
      .mod      (mod_v[gs]),
      .last     (last_v[gs]),
      .mloff_en (en_v[gs]),
      .mloff    (mloff),
      .acc      (acc_v[gs]),
      .minor    (minor_done),
      .major    (major_done),
      .addr     (addr_v[gs]),
      .err      (err_v[gs])
    );
  end

  assign src_addr     = addr_v[0];
  assign dst_addr     = addr_v[1];
  assign src_addr_err = err_v[0].addr_err;
  assign src_off_err  = err_v[0].off_err;
  assign src_size_err = err_v[0].size_err;
  assign dst_addr_err = err_v[1].addr_err;
  assign dst_off_err  = err_v[1].off_err;
  assign dst_size_err = err_v[1].size_err;
endmodule

// File: tb/dma_addr_gen_test.sv
module dma_addr_gen_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [31:0] src_start = '0, dst_start = '0, src_last = '0, dst_last = '0;
  logic [15:0] src_off = '0, dst_off = '0;
  logic [2:0]  src_size = '0, dst_size = '0;
  logic [4:0]  src_mod = '0, dst_mod = '0;
  logic        src_mloff_en = 1'b0, dst_mloff_en = 1'b0;
  logic [19:0] mloff = '0;
  logic rd_done = 1'b0, wr_done = 1'b0, minor_done = 1'b0, major_done = 1'b0;
  logic [31:0] src_addr, dst_addr;
  logic src_addr_err, src_off_err, src_size_err, dst_addr_err, dst_off_err, dst_size_err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference state, index 0 = source, 1 = destination
  logic [31:0] m_addr [2];
  logic [15:0] m_off [2];
  logic [4:0]  m_mod [2];
  logic [31:0] m_last [2];
  logic        m_en [2];
  logic [19:0] m_ml [2];
  logic [2:0]  m_err [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .load(load),
    .src_start(src_start), .src_off(src_off), .src_size(src_size), .src_mod(src_mod),
    .src_last(src_last), .src_mloff_en(src_mloff_en),
    .dst_start(dst_start), .dst_off(dst_off), .dst_size(dst_size), .dst_mod(dst_mod),
    .dst_last(dst_last), .dst_mloff_en(dst_mloff_en),
    .mloff(mloff), .rd_done(rd_done), .wr_done(wr_done),
    .minor_done(minor_done), .major_done(major_done),
    .src_addr(src_addr), .dst_addr(dst_addr),
    .src_addr_err(src_addr_err), .src_off_err(src_off_err), .src_size_err(src_size_err),
    .dst_addr_err(dst_addr_err), .dst_off_err(dst_off_err), .dst_size_err(dst_size_err)
  );

  function automatic int width_of(input logic [2:0] code);
    case (code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd4: return 16;
      3'd5: return 32;
      default: return 0;
    endcase
  endfunction

  // keep the part of old above 2^n, take the part of sum below it
  function automatic logic [31:0] m_wrap(input logic [31:0] old_a, input logic [31:0] sum,
                                         input logic [4:0] n);
    logic [63:0] p, o, s;
    if (n == 5'd0) return sum;
    p = 64'd1 << n;
    o = {32'd0, old_a};
    s = {32'd0, sum};
    return 32'((o - (o % p)) + (s % p));
  endfunction

  function automatic logic [2:0] m_check(input logic [31:0] st, input logic [15:0] of,
                                         input logic [2:0] sz);
    int w;
    logic ae, oe;
    w = width_of(sz);
    if (w == 0) return 3'b001;
    ae = (int'(st[4:0]) % w) != 0;
    oe = (int'(of[4:0]) % w) != 0;
    return {ae, oe, 1'b0};
  endfunction

  function automatic logic [31:0] m_next(input int s, input logic acc, input logic mn,
                                         input logic mj);
    logic [31:0] a;
    a = m_addr[s];
    if (acc) a = m_wrap(a, a + {{16{m_off[s][15]}}, m_off[s]}, m_mod[s]);
    if (mn && m_en[s]) a = a + {{12{m_ml[s][19]}}, m_ml[s]};
    if (mj) a = a + m_last[s];
    return a;
  endfunction

  task automatic model_step();
    if (load) begin
      m_addr[0] = src_start; m_off[0] = src_off; m_mod[0] = src_mod;
      m_last[0] = src_last;  m_en[0] = src_mloff_en; m_ml[0] = mloff;
      m_err[0]  = m_check(src_start, src_off, src_size);
      m_addr[1] = dst_start; m_off[1] = dst_off; m_mod[1] = dst_mod;
      m_last[1] = dst_last;  m_en[1] = dst_mloff_en; m_ml[1] = mloff;
      m_err[1]  = m_check(dst_start, dst_off, dst_size);
    end else begin
      if (m_err[0] == 3'b000) m_addr[0] = m_next(0, rd_done, minor_done, major_done);
      if (m_err[1] == 3'b000) m_addr[1] = m_next(1, wr_done, minor_done, major_done);
    end
  endtask

  task automatic check32(input string tag, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check32(tag, "src_addr", src_addr, m_addr[0]);
    check32(tag, "dst_addr", dst_addr, m_addr[1]);
    check32(tag, "src_err", {29'd0, src_addr_err, src_off_err, src_size_err}, {29'd0, m_err[0]});
    check32(tag, "dst_err", {29'd0, dst_addr_err, dst_off_err, dst_size_err}, {29'd0, m_err[1]});
  endtask

  // apply the inputs currently driven for one clock, then compare
  task automatic tick(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
    load = 1'b0; rd_done = 1'b0; wr_done = 1'b0; minor_done = 1'b0; major_done = 1'b0;
  endtask

  task automatic cfg_src(input logic [31:0] st, input logic [15:0] of, input logic [2:0] sz,
                         input logic [4:0] md, input logic [31:0] ls, input logic en);
    src_start = st; src_off = of; src_size = sz; src_mod = md; src_last = ls; src_mloff_en = en;
  endtask

  task automatic cfg_dst(input logic [31:0] st, input logic [15:0] of, input logic [2:0] sz,
                         input logic [4:0] md, input logic [31:0] ls, input logic en);
    dst_start = st; dst_off = of; dst_size = sz; dst_mod = md; dst_last = ls; dst_mloff_en = en;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    for (int s = 0; s < 2; s++) begin
      m_addr[s] = '0; m_off[s] = '0; m_mod[s] = '0; m_last[s] = '0;
      m_en[s] = 1'b0; m_ml[s] = '0; m_err[s] = '0;
    end
    r = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 reset");

    // R1 load, aligned configurations
    cfg_src(32'h100, 16'd4, 3'd2, 5'd0, 32'hFFFF_FFEC, 1'b1);
    cfg_dst(32'h2000, 16'hFFFE, 3'd1, 5'd0, 32'd2, 1'b0);
    mloff = 20'h10;
    load = 1'b1; tick("R1 load");
    check32("R8", "src_addr_err clear", {31'd0, src_addr_err}, 32'd0);
    // R11 source strobe leaves destination alone
    rd_done = 1'b1; tick("R11 rd only");
    check32("R3", "src step", src_addr, 32'h104);
    check32("R11", "dst untouched", dst_addr, 32'h2000);
    wr_done = 1'b1; tick("R3 negative step");
    check32("R3", "dst step", dst_addr, 32'h1FFE);
    tick("R11 idle");
    // R5 minor offset on enabled side only
    minor_done = 1'b1; tick("R5 minor");
    check32("R5", "src minor", src_addr, 32'h114);
    check32("R5", "dst disabled", dst_addr, 32'h1FFE);
    // R6 major adjustment
    major_done = 1'b1; tick("R6 major");
    check32("R6", "src major", src_addr, 32'h100);
    check32("R6", "dst major", dst_addr, 32'h2000);

    // R7 all three strobes in one cycle
    cfg_src(32'h1C, 16'd4, 3'd2, 5'd5, 32'h100, 1'b1);
    mloff = 20'h30;
    load = 1'b1; tick("R7 load");
    rd_done = 1'b1; minor_done = 1'b1; major_done = 1'b1; tick("R7 order");
    check32("R7", "ordered result", src_addr, 32'h130);

    // R4 window wrap upward and downward, no wrap, widest window
    cfg_src(32'h1000_000C, 16'd4, 3'd2, 5'd4, 32'd0, 1'b0);
    load = 1'b1; tick("R4 load");
    rd_done = 1'b1; tick("R4 up");
    check32("R4", "wrap up", src_addr, 32'h1000_0000);
    cfg_src(32'h1000_0000, 16'hFFFC, 3'd2, 5'd4, 32'd0, 1'b0);
    load = 1'b1; tick("R4 load2");
    rd_done = 1'b1; tick("R4 down");
    check32("R4", "wrap down", src_addr, 32'h1000_000C);
    cfg_src(32'h0FFF_FFFC, 16'd4, 3'd2, 5'd0, 32'd0, 1'b0);
    load = 1'b1; tick("R4 load3");
    rd_done = 1'b1; tick("R4 off");
    check32("R4", "no wrap", src_addr, 32'h1000_0000);
    cfg_src(32'hFFFF_FFFC, 16'd4, 3'd2, 5'd31, 32'd0, 1'b0);
    load = 1'b1; tick("R4 load4");
    rd_done = 1'b1; tick("R4 wide");
    check32("R4", "wide window", src_addr, 32'h8000_0000);

    // R2 every size code
    for (int c = 0; c < 8; c++) begin
      cfg_src(32'h0, 16'd0, 3'(c), 5'd0, 32'd0, 1'b0);
      load = 1'b1; tick("R2 size code");
      check32("R2", "size_err", {31'd0, src_size_err},
              {31'd0, (c == 3 || c == 6 || c == 7)});
    end
    // R8 misaligned start for 16-byte accesses
    cfg_src(32'h18, 16'd16, 3'd4, 5'd0, 32'd0, 1'b0);
    load = 1'b1; tick("R8 load");
    check32("R8", "addr_err", {31'd0, src_addr_err}, 32'd1);
    // R10 frozen while in error
    rd_done = 1'b1; major_done = 1'b1; tick("R10 frozen");
    check32("R10", "held addr", src_addr, 32'h18);
    check32("R10", "sticky", {31'd0, src_addr_err}, 32'd1);
    // R9 misaligned step
    cfg_dst(32'h40, 16'd8, 3'd4, 5'd0, 32'd0, 1'b0);
    cfg_src(32'h40, 16'd16, 3'd4, 5'd0, 32'd0, 1'b0);
    load = 1'b1; tick("R9 load");
    check32("R9", "off_err", {31'd0, dst_off_err}, 32'd1);
    check32("R10", "cleared by load", {31'd0, src_addr_err}, 32'd0);
    // R12 load beats strobes
    cfg_src(32'h300, 16'd4, 3'd2, 5'd0, 32'h40, 1'b0);
    load = 1'b1; rd_done = 1'b1; major_done = 1'b1; tick("R12 load priority");
    check32("R12", "load wins", src_addr, 32'h300);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 12) == 0) begin
        for (int s = 0; s < 2; s++) begin
          logic [31:0] st, ls;
          logic [15:0] of;
          logic [2:0] sz;
          logic [4:0] md;
          sz = 3'($urandom % 8);
          if (($urandom % 6) != 0) sz = (sz == 3'd3 || sz > 3'd5) ? 3'd2 : sz;
          st = $urandom;
          of = 16'($urandom);
          if (($urandom % 5) != 0) begin st[4:0] = 5'd0; of[4:0] = 5'd0; end
          md = 5'($urandom);
          if (($urandom % 3) == 0) md = 5'd0;
          ls = $urandom;
          if (s == 0) cfg_src(st, of, sz, md, ls, 1'($urandom));
          else        cfg_dst(st, of, sz, md, ls, 1'($urandom));
        end
        mloff = 20'($urandom);
        load = 1'b1;
      end
      rd_done    = 1'($urandom);
      wr_done    = 1'($urandom);
      minor_done = (($urandom % 4) == 0);
      major_done = (($urandom % 8) == 0);
      tick("R7 random");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule